// File: doc/BRIEF.md
# Integer Bitwise Logic Unit

This block is the combinational bitwise datapath of an integer execution pipe. From a 6-bit major opcode and a 10-bit minor opcode it selects one function and applies it to a 32-bit source operand and either a second 32-bit operand or a 16-bit immediate. The functions are the eight two-input boolean operations, sign extension from a byte or a halfword, a leading-zero count, and a per-byte equality compare that builds a byte mask. The result is ready in the same cycle the operands and opcodes are presented. The block holds no state.

The enclosing pipeline sends the operands and the opcode fields straight from the issue stage. It registers `result` wherever its own timing requires. The `cond_rec` output tells the pipeline that the immediate AND forms must also update a condition field. That update happens outside this block. The `bad_op` output marks any opcode pair this unit does not implement, so the pipeline can route it to another unit or to an exception path.

Top module: `bitlogic_unit`

## Requirements
- R1: With major opcode 31, the minor opcode selects a two-input function of the source S and operand B: 28 gives S&B, 444 gives S|B, 316 gives S^B, 476 gives ~(S&B), 124 gives ~(S|B), 284 gives ~(S^B), 60 gives S&~B and 412 gives S|~B.
- R2: With major opcode 31, minor 954 returns S[7:0] sign-extended to 32 bits, and minor 922 returns S[15:0] sign-extended to 32 bits.
- R3: With major opcode 31, minor 26 returns the number of zero bits above the highest set bit of S. The count is 31 for S=1 and 32 when S is zero.
- R4: With major opcode 31, minor 508 compares S and B one byte lane at a time (bits 7:0, 15:8, 23:16, 31:24). Each lane of the result is 0xFF when the two lanes are equal and 0x00 when they differ.
- R5: Major opcode 24 returns S OR the zero-extended immediate and 26 returns S XOR it. Major opcodes 25 and 27 do the same with the immediate placed in bits 31:16 and zeros in bits 15:0.
- R6: Major opcode 28 returns S AND the zero-extended immediate and 29 returns S AND the immediate shifted into bits 31:16. `cond_rec` is 1 for these two major opcodes and 0 for every other opcode pair.
- R7: Any other opcode pair returns a result of 0 with `bad_op` at 1. This covers major 31 with a minor not listed in R1 to R4, and any major other than 24 to 29 or 31. `bad_op` is 0 for every implemented pair.
- R8: The forms in R1 to R4 ignore the immediate, and the forms in R5 and R6 ignore both B and the minor opcode. Changing an ignored input leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_major | input | 6 | Major opcode |
| op_minor | input | 10 | Minor opcode, used only when op_major is 31 |
| src_s | input | 32 | Source operand S |
| src_b | input | 32 | Second operand B for the register forms |
| imm | input | 16 | Unsigned immediate for the immediate forms |
| result | output | 32 | Function result, zero for an unimplemented opcode |
| cond_rec | output | 1 | The immediate AND forms ask for a condition update |
| bad_op | output | 1 | Opcode pair not implemented by this unit |

## Verification
The immediate assertions inside the modules assume that every input carries a known 0 or 1 value. They also assume that all five inputs change together, so that each evaluation sees one consistent opcode and operand set. The bench keeps to this. It drives every input with a defined value in a single step shortly after a clock edge, and it compares the outputs only at the following falling edge. Random operands come from a fully specified 32-bit source, and opcodes are drawn both from the implemented set and at random across all 16 bits. This makes sure the unimplemented-opcode path sees the same clean inputs as the implemented forms.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int DATA_W  = 32;
    localparam int IMM_W   = 16;
    localparam int LANE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int MAJ_W   = 6;
    localparam int MIN_W   = 10;

    // major opcodes
    localparam logic [MAJ_W-1:0] MAJ_REG    = 6'd31;
    localparam logic [MAJ_W-1:0] MAJ_ORI    = 6'd24;
    localparam logic [MAJ_W-1:0] MAJ_ORI_H  = 6'd25;
    localparam logic [MAJ_W-1:0] MAJ_XORI   = 6'd26;
    localparam logic [MAJ_W-1:0] MAJ_XORI_H = 6'd27;
    localparam logic [MAJ_W-1:0] MAJ_ANDI   = 6'd28;
    localparam logic [MAJ_W-1:0] MAJ_ANDI_H = 6'd29;

    // minor opcodes under MAJ_REG
    localparam logic [MIN_W-1:0] MIN_AND   = 10'd28;
    localparam logic [MIN_W-1:0] MIN_OR    = 10'd444;
    localparam logic [MIN_W-1:0] MIN_XOR   = 10'd316;
    localparam logic [MIN_W-1:0] MIN_NAND  = 10'd476;
    localparam logic [MIN_W-1:0] MIN_NOR   = 10'd124;
    localparam logic [MIN_W-1:0] MIN_XNOR  = 10'd284;
    localparam logic [MIN_W-1:0] MIN_ANDN  = 10'd60;
    localparam logic [MIN_W-1:0] MIN_ORN   = 10'd412;
    localparam logic [MIN_W-1:0] MIN_SXB   = 10'd954;
    localparam logic [MIN_W-1:0] MIN_SXH   = 10'd922;
    localparam logic [MIN_W-1:0] MIN_LZC   = 10'd26;
    localparam logic [MIN_W-1:0] MIN_LANEQ = 10'd508;

    typedef enum logic [3:0] {
        FN_AND,
        FN_OR,
        FN_XOR,
        FN_NAND,
        FN_NOR,
        FN_XNOR,
        FN_ANDN,
        FN_ORN,
        FN_SXB,
        FN_SXH,
        FN_LZC,
        FN_LANEQ,
        FN_NONE
    } lu_fn_e;

    typedef struct packed {
        lu_fn_e fn;
        logic   use_imm;  // operand B taken from the immediate
        logic   imm_hi;   // immediate placed in the upper half
        logic   rec;      // condition update requested
        logic   bad;      // opcode pair not implemented
    } lu_ctrl_t;

    function automatic logic is_gate(lu_fn_e f);
        return (f == FN_AND) || (f == FN_OR) || (f == FN_XOR) ||
               (f == FN_NAND) || (f == FN_NOR) || (f == FN_XNOR) ||
               (f == FN_ANDN) || (f == FN_ORN) || (f == FN_SXB) ||
               (f == FN_SXH);
    endfunction

endpackage

// File: rtl/lu_decode.sv
module lu_decode
    import lu_pkg::*;
(
    input  logic [MAJ_W-1:0] op_major,
    input  logic [MIN_W-1:0] op_minor,
    output lu_ctrl_t         ctrl
);

    lu_fn_e reg_fn;
    logic   reg_bad;

    always_comb begin
        reg_bad = 1'b0;
        unique case (op_minor)
            MIN_AND:   reg_fn = FN_AND;
            MIN_OR:    reg_fn = FN_OR;
            MIN_XOR:   reg_fn = FN_XOR;
            MIN_NAND:  reg_fn = FN_NAND;
            MIN_NOR:   reg_fn = FN_NOR;
            MIN_XNOR:  reg_fn = FN_XNOR;
            MIN_ANDN:  reg_fn = FN_ANDN;
            MIN_ORN:   reg_fn = FN_ORN;
            MIN_SXB:   reg_fn = FN_SXB;
            MIN_SXH:   reg_fn = FN_SXH;
            MIN_LZC:   reg_fn = FN_LZC;
            MIN_LANEQ: reg_fn = FN_LANEQ;
            default: begin
                reg_fn  = FN_NONE;
                reg_bad = 1'b1;
            end
        endcase
    end

    always_comb begin
        ctrl = '{fn: FN_NONE, use_imm: 1'b0, imm_hi: 1'b0, rec: 1'b0, bad: 1'b1};
        unique case (op_major)
            MAJ_REG: begin
                ctrl.fn  = reg_fn;
                ctrl.bad = reg_bad;
            end
            MAJ_ORI, MAJ_ORI_H: begin
                ctrl = '{fn: FN_OR, use_imm: 1'b1, imm_hi: op_major[0], rec: 1'b0, bad: 1'b0};
            end
            MAJ_XORI, MAJ_XORI_H: begin
                ctrl = '{fn: FN_XOR, use_imm: 1'b1, imm_hi: op_major[0], rec: 1'b0, bad: 1'b0};
            end
            MAJ_ANDI, MAJ_ANDI_H: begin
                ctrl = '{fn: FN_AND, use_imm: 1'b1, imm_hi: op_major[0], rec: 1'b1, bad: 1'b0};
            end
            default: ;
        endcase
    end

    always_comb begin
        if (ctrl.use_imm) begin
            AST_IMM_NOT_REG: assert (op_major != MAJ_REG); // R8
        end
    end

endmodule

// File: rtl/lu_gates.sv
module lu_gates
    import lu_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int SX_A = LANE_W,
    parameter int SX_B = HALF_W
) (
    input  lu_fn_e       fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam int PAD_A = W - SX_A;
    localparam int PAD_B = W - SX_B;

    logic [W-1:0] sx_a;
    logic [W-1:0] sx_b;

    assign sx_a = {{PAD_A{a[SX_A-1]}}, a[SX_A-1:0]};
    assign sx_b = {{PAD_B{a[SX_B-1]}}, a[SX_B-1:0]};

    always_comb begin
        unique case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_NAND: y = ~(a & b);
            FN_NOR:  y = ~(a | b);
            FN_XNOR: y = ~(a ^ b);
            FN_ANDN: y = a & ~b;
            FN_ORN:  y = a | ~b;
            FN_SXB:  y = sx_a;
            FN_SXH:  y = sx_b;
            default: y = '0;
        endcase
    end

    always_comb begin
        if (fn == FN_SXB) begin
            AST_SXB_LOW_KEPT: assert (y[SX_A-1:0] == a[SX_A-1:0]); // R2
        end
    end

endmodule

// File: rtl/lu_lzc.sv
module lu_lzc #(
    parameter int W     = 32,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  a,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (a[i]) cnt = CW'(W - 1 - i);
        end
    end

    always_comb begin
        AST_LZC_RANGE: assert (int'(cnt) <= W); // R3
        if (int'(cnt) < W) begin
            AST_LZC_LEAD_ONE: assert (a[W - 1 - int'(cnt)] == 1'b1); // R3
        end
    end

endmodule

// File: rtl/lu_laneq.sv
module lu_laneq #(
    parameter int W      = 32,
    parameter int LANE   = 8,
    localparam int NLANE = W / LANE
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic hit;
        assign hit = (a[g*LANE +: LANE] == b[g*LANE +: LANE]);
        assign y[g*LANE +: LANE] = {LANE{hit}};
    end

endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
    import lu_pkg::*;
(
    input  logic [5:0]  op_major,
    input  logic [9:0]  op_minor,
    input  logic [31:0] src_s,
    input  logic [31:0] src_b,
    input  logic [15:0] imm,
    output logic [31:0] result,
    output logic        cond_rec,
    output logic        bad_op
);

    localparam int CW    = $clog2(DATA_W + 1);
    localparam int SHIFT = DATA_W - IMM_W;

    lu_ctrl_t          ctrl;
    logic [DATA_W-1:0] imm_lo;
    logic [DATA_W-1:0] imm_up;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] gate_y;
    logic [DATA_W-1:0] laneq_y;
    logic [CW-1:0]     lzc_cnt;

    lu_decode u_dec (
        .op_major (op_major),
        .op_minor (op_minor),
        .ctrl     (ctrl)
    );

    assign imm_lo = {{SHIFT{1'b0}}, imm};
    assign imm_up = {imm, {SHIFT{1'b0}}};
    assign opnd_b = !ctrl.use_imm ? src_b : (ctrl.imm_hi ? imm_up : imm_lo);

    lu_gates #(.W(DATA_W), .SX_A(LANE_W), .SX_B(HALF_W)) u_gates (
        .fn (ctrl.fn),
        .a  (src_s),
        .b  (opnd_b),
        .y  (gate_y)
    );

    lu_lzc #(.W(DATA_W)) u_lzc (
        .a   (src_s),
        .cnt (lzc_cnt)
    );

    lu_laneq #(.W(DATA_W), .LANE(LANE_W)) u_laneq (
        .a (src_s),
        .b (opnd_b),
        .y (laneq_y)
    );

    always_comb begin
        if (ctrl.bad)                 result = '0;
        else if (is_gate(ctrl.fn))    result = gate_y;
        else if (ctrl.fn == FN_LZC)   result = {{(DATA_W-CW){1'b0}}, lzc_cnt};
        else if (ctrl.fn == FN_LANEQ) result = laneq_y;
        else                          result = '0;
    end

    assign cond_rec = ctrl.rec;
    assign bad_op   = ctrl.bad;

    always_comb begin
        if (bad_op) begin
            AST_BAD_ZERO: assert (result == '0); // R7
        end
        if (cond_rec) begin
            AST_REC_KNOWN: assert (!bad_op && op_major[5:1] == 5'd14); // R6
        end
        if (!bad_op && op_major == MAJ_REG && op_minor == MIN_LANEQ && src_s == src_b) begin
            AST_LANEQ_SELF: assert (result == '1); // R4
        end
    end

endmodule

// File: tb/tb_bitlogic_unit.sv
module tb_bitlogic_unit;

    logic        clk = 1'b0;
    logic [5:0]  op_major = '0;
    logic [9:0]  op_minor = '0;
    logic [31:0] src_s = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;
    logic        cond_rec;
    logic        bad_op;

    int n_cmp  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bitlogic_unit dut (
        .op_major (op_major),
        .op_minor (op_minor),
        .src_s    (src_s),
        .src_b    (src_b),
        .imm      (imm),
        .result   (result),
        .cond_rec (cond_rec),
        .bad_op   (bad_op)
    );

    // {major, minor, S, B, imm, expected result, expected cond_rec, expected bad_op}
    localparam int NV = 26;
    localparam logic [129:0] VEC [NV] = '{
        {6'd31, 10'd28,  32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0000, 32'h00F0_1234, 1'b0, 1'b0}, // R1 and
        {6'd31, 10'd316, 32'hFFFF_0000, 32'h0F0F_0F0F, 16'h0000, 32'hF0F0_0F0F, 1'b0, 1'b0}, // R1 xor
        {6'd31, 10'd476, 32'hFFFF_FFFF, 32'hFFFF_0000, 16'h0000, 32'h0000_FFFF, 1'b0, 1'b0}, // R1 nand
        {6'd31, 10'd444, 32'h1200_0000, 32'h0000_0034, 16'h0000, 32'h1200_0034, 1'b0, 1'b0}, // R1 or
        {6'd31, 10'd124, 32'h0000_0000, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R1 nor
        {6'd31, 10'd60,  32'hFFFF_FFFF, 32'h0000_FFFF, 16'h0000, 32'hFFFF_0000, 1'b0, 1'b0}, // R1 andn
        {6'd31, 10'd284, 32'hAAAA_AAAA, 32'hAAAA_5555, 16'h0000, 32'hFFFF_0000, 1'b0, 1'b0}, // R1 xnor
        {6'd31, 10'd412, 32'h0000_0000, 32'hFFFF_FFFE, 16'h0000, 32'h0000_0001, 1'b0, 1'b0}, // R1 orn
        {6'd31, 10'd954, 32'h1234_5680, 32'h0000_0000, 16'h0000, 32'hFFFF_FF80, 1'b0, 1'b0}, // R2
        {6'd31, 10'd954, 32'hFFFF_FF7F, 32'h0000_0000, 16'h0000, 32'h0000_007F, 1'b0, 1'b0}, // R2
        {6'd31, 10'd922, 32'h0000_8001, 32'h0000_0000, 16'h0000, 32'hFFFF_8001, 1'b0, 1'b0}, // R2
        {6'd31, 10'd26,  32'h0000_0000, 32'h0000_0000, 16'h0000, 32'h0000_0020, 1'b0, 1'b0}, // R3
        {6'd31, 10'd26,  32'h0000_0001, 32'h0000_0000, 16'h0000, 32'h0000_001F, 1'b0, 1'b0}, // R3
        {6'd31, 10'd26,  32'h8000_0000, 32'h0000_0000, 16'h0000, 32'h0000_0000, 1'b0, 1'b0}, // R3
        {6'd31, 10'd26,  32'h0001_FFFF, 32'h0000_0000, 16'h0000, 32'h0000_000F, 1'b0, 1'b0}, // R3
        {6'd31, 10'd508, 32'h1122_3344, 32'h1199_3300, 16'h0000, 32'hFF00_FF00, 1'b0, 1'b0}, // R4
        {6'd24, 10'd0,   32'h1234_0000, 32'hDEAD_BEEF, 16'hABCD, 32'h1234_ABCD, 1'b0, 1'b0}, // R5
        {6'd25, 10'd0,   32'h0000_1111, 32'hDEAD_BEEF, 16'hABCD, 32'hABCD_1111, 1'b0, 1'b0}, // R5
        {6'd26, 10'd0,   32'hFFFF_FFFF, 32'hDEAD_BEEF, 16'h00FF, 32'hFFFF_FF00, 1'b0, 1'b0}, // R5
        {6'd27, 10'd0,   32'hFFFF_FFFF, 32'hDEAD_BEEF, 16'h00FF, 32'hFF00_FFFF, 1'b0, 1'b0}, // R5
        {6'd28, 10'd0,   32'hFFFF_FFFF, 32'hDEAD_BEEF, 16'h8001, 32'h0000_8001, 1'b1, 1'b0}, // R6
        {6'd29, 10'd0,   32'hFFFF_FFFF, 32'hDEAD_BEEF, 16'h8001, 32'h8001_0000, 1'b1, 1'b0}, // R6
        {6'd31, 10'd27,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000, 1'b0, 1'b1}, // R7
        {6'd30, 10'd28,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 32'h0000_0000, 1'b0, 1'b1}, // R7
        {6'd31, 10'd28,  32'hF0F0_1234, 32'h0FF0_FFFF, 16'hFFFF, 32'h00F0_1234, 1'b0, 1'b0}, // R8 imm ignored
        {6'd24, 10'd444, 32'h0000_0000, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0001, 1'b0, 1'b0}  // R8 B, minor ignored
    };

    localparam int NEXT = 12;
    localparam logic [9:0] EXT_OPS [NEXT] = '{10'd28, 10'd316, 10'd476, 10'd444, 10'd124,
        10'd60, 10'd284, 10'd412, 10'd954, 10'd922, 10'd26, 10'd508};

    // model from the requirements: {cond_rec, bad_op, result}
    function automatic logic [33:0] model(logic [5:0] mj, logic [9:0] mn,
                                          logic [31:0] s, logic [31:0] b, logic [15:0] im);
        logic [31:0] r;
        logic [31:0] lo;
        logic [31:0] up;
        logic        bad;
        logic        found;
        r = '0;
        bad = 1'b0;
        lo = {16'h0, im};
        up = {im, 16'h0};
        case (mj)
            6'd24: r = s | lo;
            6'd25: r = s | up;
            6'd26: r = s ^ lo;
            6'd27: r = s ^ up;
            6'd28: r = s & lo;
            6'd29: r = s & up;
            6'd31: begin
                case (mn)
                    10'd28:  r = s & b;
                    10'd444: r = s | b;
                    10'd316: r = s ^ b;
                    10'd476: r = ~(s & b);
                    10'd124: r = ~(s | b);
                    10'd284: r = ~(s ^ b);
                    10'd60:  r = s & ~b;
                    10'd412: r = s | ~b;
                    10'd954: r = {{24{s[7]}}, s[7:0]};
                    10'd922: r = {{16{s[15]}}, s[15:0]};
                    10'd26: begin
                        r = 32'd32;
                        found = 1'b0;
                        for (int i = 31; i >= 0; i--) begin
                            if (!found && s[i]) begin
                                r = 32'(31 - i);
                                found = 1'b1;
                            end
                        end
                    end
                    10'd508: begin
                        for (int k = 0; k < 4; k++)
                            r[k*8 +: 8] = (s[k*8 +: 8] == b[k*8 +: 8]) ? 8'hFF : 8'h00;
                    end
                    default: bad = 1'b1;
                endcase
            end
            default: bad = 1'b1;
        endcase
        return {(mj == 6'd28 || mj == 6'd29), bad, r};
    endfunction

    task automatic apply(logic [5:0] mj, logic [9:0] mn, logic [31:0] s,
                         logic [31:0] b, logic [15:0] im);
        @(posedge clk);
        #1;
        op_major = mj;
        op_minor = mn;
        src_s = s;
        src_b = b;
        imm = im;
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] er, logic erec, logic ebad);
        n_cmp++;
        if (result !== er || cond_rec !== erec || bad_op !== ebad) begin
            n_fail++;
            $display("FAIL %s: maj=%0d min=%0d got result=%h rec=%b bad=%b expected result=%h rec=%b bad=%b",
                     req, op_major, op_minor, result, cond_rec, bad_op, er, erec, ebad);
        end
    endtask

    function automatic string req_of(logic [5:0] mj, logic [9:0] mn);
        if (mj == 6'd28 || mj == 6'd29) return "R6";
        if (mj >= 6'd24 && mj <= 6'd27) return "R5";
        if (mj != 6'd31) return "R7";
        case (mn)
            10'd954, 10'd922: return "R2";
            10'd26:  return "R3";
            10'd508: return "R4";
            10'd28, 10'd444, 10'd316, 10'd476, 10'd124, 10'd284, 10'd60, 10'd412: return "R1";
            default: return "R7";
        endcase
    endfunction

    task automatic run_model(logic [5:0] mj, logic [9:0] mn, logic [31:0] s,
                             logic [31:0] b, logic [15:0] im);
        logic [33:0] e;
        e = model(mj, mn, s, b, im);
        apply(mj, mn, s, b, im);
        check(req_of(mj, mn), e[31:0], e[33], e[32]);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        // initial state: all-zero inputs are AND-immediate? no: major 0 is unimplemented, R7
        @(negedge clk);
        check("R7", 32'h0, 1'b0, 1'b1);

        // directed table
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][129:124], VEC[v][123:114], VEC[v][113:82], VEC[v][81:50], VEC[v][49:34]);
            check(req_of(VEC[v][129:124], VEC[v][123:114]), VEC[v][33:2], VEC[v][1], VEC[v][0]);
        end

        // R3 and R2 on every single-bit source
        for (int k = 0; k < 32; k++) begin
            run_model(6'd31, 10'd26, 32'h1 << k, 32'h0, 16'h0);
            run_model(6'd31, 10'd954, 32'h1 << k, 32'h0, 16'h0);
            run_model(6'd31, 10'd922, 32'h1 << k, 32'h0, 16'h0);
            run_model(6'd31, 10'd508, 32'h1 << k, 32'h0, 16'h0);
        end

        // all-zero and all-one corners on every implemented form
        for (int c = 0; c < 4; c++) begin
            logic [31:0] cs;
            logic [31:0] cb;
            cs = c[0] ? 32'hFFFF_FFFF : 32'h0;
            cb = c[1] ? 32'hFFFF_FFFF : 32'h0;
            for (int j = 0; j < NEXT; j++) run_model(6'd31, EXT_OPS[j], cs, cb, 16'hFFFF);
            for (int m = 24; m < 30; m++) run_model(6'(m), 10'd0, cs, cb, cb[15:0]);
        end

        // random sweep of every form, R8 via random ignored inputs
        for (int t = 0; t < 200; t++) begin
            for (int j = 0; j < NEXT; j++)
                run_model(6'd31, EXT_OPS[j], $urandom, $urandom, 16'($urandom));
            for (int m = 24; m < 30; m++)
                run_model(6'(m), 10'($urandom), $urandom, $urandom, 16'($urandom));
            run_model(6'($urandom), 10'($urandom), $urandom, $urandom, 16'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule